// File: doc/BRIEF.md
# Pipelined Complex Multiplier

This block forms the product of two signed complex numbers, A = a_re + j·a_im and B = b_re + j·b_im. It returns the real and imaginary parts of that product at full precision. The real and imaginary parts of A share one width, AW. The parts of B share another width, BW. Both widths may be set from 8 to 63 bits. Each output part is AW+BW bits wide. Choosing an output bit range and rounding the result belong to a separate block downstream.

A build-time parameter selects the arithmetic structure. The four-product form computes the two parts directly. The three-product form first builds sums and differences of the operands, then shares one product between the real and imaginary paths. The pipeline has three natural register stages: operands or pre-sums, products, and the combined result. The LATENCY parameter (0 to 50) decides how many of those stages are registered. Any latency above three is made up by plain delay registers at the output. A clock enable freezes every register. A synchronous clear zeroes every register, and a parameter decides whether the clear or the clock enable takes precedence. At latency zero the block is purely combinational.

Top module: `cmul_top`

## Requirements
- R1: With MODE_FOUR, p_re equals a_re·b_re − a_im·b_im and p_im equals a_re·b_im + a_im·b_re. All values are two's complement, and each result is taken modulo 2^(AW+BW).
- R2: With MODE_THREE, both outputs are bit-identical to R1 for every input, including operands that hold their most negative values.
- R3: With clock enable held high, the outputs show the product of the inputs that were present LATENCY rising edges earlier.
- R4: While clock enable is low and clear is inactive, every register holds its value. The outputs stay stable, and when enable returns no pipeline data has been lost.
- R5: With CLEAR_WINS = 1, a clear zeroes every register even in a cycle where clock enable is low.
- R6: With CLEAR_WINS = 0, a clear in a cycle where clock enable is low has no effect. A clear in a cycle where clock enable is high zeroes every register.
- R7: After a clear, both outputs read zero until LATENCY enabled clock edges have passed.
- R8: With LATENCY = 0, the outputs follow the inputs combinationally, and ce and clr have no effect.
- R9: p_re never takes the most negative value 1000…0. p_im takes that value only when a_re and b_im both hold their minimum and a_im and b_re both hold their minimum; this is the single case that wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Clock enable, active high |
| clr | input | 1 | Synchronous clear, active high |
| a_re | input | AW | Real part of operand A |
| a_im | input | AW | Imaginary part of operand A |
| b_re | input | BW | Real part of operand B |
| b_im | input | BW | Imaginary part of operand B |
| p_re | output | AW+BW | Real part of the product |
| p_im | output | AW+BW | Imaginary part of the product |

## Verification
The bench builds three copies of the block.

- A 16×16 copy uses the three-product form with latency 4 and clear taking precedence. This exercises the pre-adders and the single output delay register.
- A 16×16 copy uses the four-product form with latency 0. It serves as a combinational cross-check of the three-product copy on the same vectors, including all-minimum operands.
- An 8×10 copy uses the four-product form with latency 6 and clock enable taking precedence. It reaches the deeper output delay line, the gated clear, and unequal operand widths, where the all-minimum product wraps in the imaginary part.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Arithmetic structure of the multiplier core
    typedef enum logic {
        MODE_FOUR  = 1'b0,
        MODE_THREE = 1'b1
    } cmul_mode_e;

    // Register stages inside the core: operands, products, combined result
    localparam int CORE_STAGES = 3;

    function automatic int core_regs(input int latency);
        return (latency < CORE_STAGES) ? latency : CORE_STAGES;
    endfunction

    function automatic int tail_regs(input int latency);
        return (latency > CORE_STAGES) ? latency - CORE_STAGES : 0;
    endfunction

endpackage

// File: rtl/cmul_stage.sv
module cmul_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         step,
    input  logic         clr_hit,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (clr_hit) begin
                    q <= '0;
                end else if (step) begin
                    q <= d;
                end
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/cmul_delay.sv
module cmul_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         step,
    input  logic         clr_hit,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_none
            assign q = d;
        end else begin : g_line
            logic [W-1:0] pipe [DEPTH];

            always_ff @(posedge clk) begin
                if (clr_hit) begin
                    for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
                end else if (step) begin
                    pipe[0] <= d;
                    for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign q = pipe[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cmul_core.sv
module cmul_core
    import cmul_pkg::*;
#(
    parameter int         AW   = 16,
    parameter int         BW   = 16,
    parameter cmul_mode_e MODE = MODE_THREE,
    parameter int         REGS = 3
) (
    input  logic            clk,
    input  logic            step,
    input  logic            clr_hit,
    input  logic [AW-1:0]   a_re,
    input  logic [AW-1:0]   a_im,
    input  logic [BW-1:0]   b_re,
    input  logic [BW-1:0]   b_im,
    output logic [AW+BW-1:0] r_re,
    output logic [AW+BW-1:0] r_im
);

    localparam int  PW    = AW + BW;
    localparam bit  REG_A = (REGS >= 1);
    localparam bit  REG_B = (REGS >= 2);
    localparam bit  REG_C = (REGS >= 3);
    localparam int  WC    = 2 * PW;

    logic [WC-1:0] vc_d, vc_q;

    generate
        if (MODE == MODE_THREE) begin : g_three
            localparam int WA = AW + 2 * (AW + 1) + (BW + 1) + 2 * BW;
            localparam int WB = 3 * (PW + 1);

            logic signed [AW:0] sum_a, dif_a;
            logic signed [BW:0] sum_b;
            logic [WA-1:0]      va_d, va_q;
            logic [AW-1:0]      q_ar;
            logic [AW:0]        q_sa, q_da;
            logic [BW:0]        q_sb;
            logic [BW-1:0]      q_bi, q_br;
            logic signed [PW:0] m_sh, m_sa, m_da;
            logic [WB-1:0]      vb_d, vb_q;
            logic [PW:0]        n_sh, n_sa, n_da;

            // Pre-adders: each adds one bit to its multiplier input
            assign sum_a = (AW+1)'($signed(a_re)) + (AW+1)'($signed(a_im));
            assign dif_a = (AW+1)'($signed(a_im)) - (AW+1)'($signed(a_re));
            assign sum_b = (BW+1)'($signed(b_re)) + (BW+1)'($signed(b_im));
            assign va_d  = {a_re, sum_a, dif_a, sum_b, b_im, b_re};

            cmul_stage #(.W(WA), .REG(REG_A)) u_sa (
                .clk(clk), .step(step), .clr_hit(clr_hit), .d(va_d), .q(va_q)
            );

            assign {q_ar, q_sa, q_da, q_sb, q_bi, q_br} = va_q;

            // Shared product and the two correction products
            assign m_sh = (PW+1)'($signed(q_ar)) * (PW+1)'($signed(q_sb));
            assign m_sa = (PW+1)'($signed(q_sa)) * (PW+1)'($signed(q_bi));
            assign m_da = (PW+1)'($signed(q_da)) * (PW+1)'($signed(q_br));
            assign vb_d = {m_sh, m_sa, m_da};

            cmul_stage #(.W(WB), .REG(REG_B)) u_sb (
                .clk(clk), .step(step), .clr_hit(clr_hit), .d(vb_d), .q(vb_q)
            );

            assign {n_sh, n_sa, n_da} = vb_q;
            assign vc_d = {PW'(n_sh - n_sa), PW'(n_sh + n_da)};
        end else begin : g_four
            localparam int WA = 2 * AW + 2 * BW;
            localparam int WB = 4 * PW;

            logic [WA-1:0]       va_d, va_q;
            logic [AW-1:0]       q_ar, q_ai;
            logic [BW-1:0]       q_br, q_bi;
            logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
            logic [WB-1:0]       vb_d, vb_q;
            logic [PW-1:0]       n_rr, n_ii, n_ri, n_ir;

            assign va_d = {a_re, a_im, b_re, b_im};

            cmul_stage #(.W(WA), .REG(REG_A)) u_sa (
                .clk(clk), .step(step), .clr_hit(clr_hit), .d(va_d), .q(va_q)
            );

            assign {q_ar, q_ai, q_br, q_bi} = va_q;

            assign m_rr = PW'($signed(q_ar)) * PW'($signed(q_br));
            assign m_ii = PW'($signed(q_ai)) * PW'($signed(q_bi));
            assign m_ri = PW'($signed(q_ar)) * PW'($signed(q_bi));
            assign m_ir = PW'($signed(q_ai)) * PW'($signed(q_br));
            assign vb_d = {m_rr, m_ii, m_ri, m_ir};

            cmul_stage #(.W(WB), .REG(REG_B)) u_sb (
                .clk(clk), .step(step), .clr_hit(clr_hit), .d(vb_d), .q(vb_q)
            );

            assign {n_rr, n_ii, n_ri, n_ir} = vb_q;
            assign vc_d = {PW'(n_rr - n_ii), PW'(n_ri + n_ir)};
        end
    endgenerate

    cmul_stage #(.W(WC), .REG(REG_C)) u_sc (
        .clk(clk), .step(step), .clr_hit(clr_hit), .d(vc_d), .q(vc_q)
    );

    assign {r_re, r_im} = vc_q;

endmodule

// File: rtl/cmul_top.sv
module cmul_top
    import cmul_pkg::*;
#(
    parameter int         AW         = 16,
    parameter int         BW         = 16,
    parameter cmul_mode_e MODE       = MODE_THREE,
    parameter int         LATENCY    = 4,
    parameter bit         CLEAR_WINS = 1'b1
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             clr,
    input  logic [AW-1:0]    a_re,
    input  logic [AW-1:0]    a_im,
    input  logic [BW-1:0]    b_re,
    input  logic [BW-1:0]    b_im,
    output logic [AW+BW-1:0] p_re,
    output logic [AW+BW-1:0] p_im
);

    localparam int PW    = AW + BW;
    localparam int NREG  = core_regs(LATENCY);
    localparam int NTAIL = tail_regs(LATENCY);

    logic          clr_hit;
    logic [PW-1:0] c_re, c_im;
    logic [2*PW-1:0] tail_q;

    // Precedence between clear and enable
    assign clr_hit = CLEAR_WINS ? clr : (clr & ce);

    cmul_core #(.AW(AW), .BW(BW), .MODE(MODE), .REGS(NREG)) u_core (
        .clk(clk), .step(ce), .clr_hit(clr_hit),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .r_re(c_re), .r_im(c_im)
    );

    cmul_delay #(.W(2*PW), .DEPTH(NTAIL)) u_tail (
        .clk(clk), .step(ce), .clr_hit(clr_hit),
        .d({c_re, c_im}), .q(tail_q)
    );

    assign {p_re, p_im} = tail_q;

endmodule

// File: rtl/cmul_chk.sv
module cmul_chk #(
    parameter int PW         = 32,
    parameter int LATENCY    = 4,
    parameter bit CLEAR_WINS = 1'b1
) (
    input logic          clk,
    input logic          ce,
    input logic          clr,
    input logic [PW-1:0] p_re,
    input logic [PW-1:0] p_im
);

    logic       armed = 1'b0;
    logic [6:0] steps = '0;
    logic       clr_seen;

    assign clr_seen = CLEAR_WINS ? clr : (clr & ce);

    always_ff @(posedge clk) begin
        if (clr_seen) begin
            armed <= 1'b1;
            steps <= '0;
        end else if (ce && (steps < 7'(LATENCY))) begin
            steps <= steps + 7'd1;
        end
    end

    // R9: real part is always representable without reaching the minimum
    assert_real_range_R9: assert property (@(posedge clk) disable iff (!armed)
        p_re != {1'b1, {(PW-1){1'b0}}});

    generate
        if (LATENCY > 0) begin : g_seq
            assert_flush_zero_R7: assert property (@(posedge clk) disable iff (!armed)
                (steps < 7'(LATENCY)) |-> (p_re == '0 && p_im == '0));

            assert_hold_R4: assert property (@(posedge clk) disable iff (!armed)
                (!ce && !clr) |=> ($stable(p_re) && $stable(p_im)));

            if (CLEAR_WINS) begin : g_cw
                assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!armed)
                    clr |=> (p_re == '0 && p_im == '0));
            end else begin : g_ew
                assert_clear_gated_R6: assert property (@(posedge clk) disable iff (!armed)
                    (clr && !ce) |=> ($stable(p_re) && $stable(p_im)));
            end
        end
    endgenerate

endmodule

bind cmul_top cmul_chk #(.PW(PW), .LATENCY(LATENCY), .CLEAR_WINS(CLEAR_WINS)) u_chk (
    .clk(clk), .ce(ce), .clr(clr), .p_re(p_re), .p_im(p_im)
);

// File: tb/sim_cmul_top.sv
module sim_cmul_top;
    import cmul_pkg::*;

    localparam int NV = 8;
    // Each entry: {a_re, a_im, b_re, b_im}, 16 bits each
    localparam logic [63:0] VEC [NV] = '{
        64'h8000_8000_8000_8000,
        64'h0001_0000_0001_0000,
        64'h0003_FFFE_0005_0007,
        64'h7FFF_7FFF_7FFF_8000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h1234_FA99_7ABC_0101,
        64'h8000_7FFF_8000_7FFF,
        64'h8000_8000_8000_7FFF
    };

    logic        clk = 1'b0;
    logic        ce  = 1'b1;
    logic        clr = 1'b0;
    logic [15:0] ar = '0, ai = '0, br = '0, bi = '0;
    logic [31:0] o0_re, o0_im, o1_re, o1_im;
    logic [17:0] o2_re, o2_im;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    cmul_top #(.AW(16), .BW(16), .MODE(MODE_THREE), .LATENCY(4), .CLEAR_WINS(1'b1)) u0 (
        .clk(clk), .ce(ce), .clr(clr), .a_re(ar), .a_im(ai), .b_re(br), .b_im(bi),
        .p_re(o0_re), .p_im(o0_im));

    cmul_top #(.AW(16), .BW(16), .MODE(MODE_FOUR), .LATENCY(0), .CLEAR_WINS(1'b1)) u1 (
        .clk(clk), .ce(ce), .clr(clr), .a_re(ar), .a_im(ai), .b_re(br), .b_im(bi),
        .p_re(o1_re), .p_im(o1_im));

    cmul_top #(.AW(8), .BW(10), .MODE(MODE_FOUR), .LATENCY(6), .CLEAR_WINS(1'b0)) u2 (
        .clk(clk), .ce(ce), .clr(clr), .a_re(ar[7:0]), .a_im(ai[7:0]),
        .b_re(br[9:0]), .b_im(bi[9:0]), .p_re(o2_re), .p_im(o2_im));

    function automatic longint wrapw(input longint v, input int w);
        longint m;
        m = v & ((64'sd1 <<< w) - 64'sd1);
        if (m[w-1]) m = m - (64'sd1 <<< w);
        return m;
    endfunction

    function automatic logic [63:0] vec_at(input int m);
        return (m >= 0 && m < NV) ? VEC[m] : 64'h0;
    endfunction

    // Reference product, widths aw/bw, result modulo 2^(aw+bw)
    task automatic ref_mul(input logic [63:0] v, input int aw, input int bw,
                           output longint re, output longint im);
        longint xr, xi, yr, yi;
        xr = wrapw(longint'(v[63:48]), aw);
        xi = wrapw(longint'(v[47:32]), aw);
        yr = wrapw(longint'(v[31:16]), bw);
        yi = wrapw(longint'(v[15:0]),  bw);
        re = wrapw(xr * yr - xi * yi, aw + bw);
        im = wrapw(xr * yi + xi * yr, aw + bw);
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_u0(input string tag, input logic [63:0] v);
        longint re, im;
        ref_mul(v, 16, 16, re, im);
        chk({tag, " u0 re"}, wrapw(longint'(o0_re), 32), re);
        chk({tag, " u0 im"}, wrapw(longint'(o0_im), 32), im);
    endtask

    task automatic chk_u1(input string tag, input logic [63:0] v);
        longint re, im;
        ref_mul(v, 16, 16, re, im);
        chk({tag, " u1 re"}, wrapw(longint'(o1_re), 32), re);
        chk({tag, " u1 im"}, wrapw(longint'(o1_im), 32), im);
    endtask

    task automatic chk_u2(input string tag, input logic [63:0] v);
        longint re, im;
        ref_mul(v, 8, 10, re, im);
        chk({tag, " u2 re"}, wrapw(longint'(o2_re), 18), re);
        chk({tag, " u2 im"}, wrapw(longint'(o2_im), 18), im);
    endtask

    task automatic drive(input logic [63:0] v);
        {ar, ai, br, bi} = v;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset: clear with enable high
        @(negedge clk);
        clr = 1'b1;
        ce  = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 reset", longint'(o0_re | o0_im | 32'(o2_re) | 32'(o2_im)), 0);

        // Streaming table: R1 (u1, u2), R2 (u0 vs reference), R3 latency, R7 flush
        for (int m = 0; m < NV + 6; m++) begin
            if (m > 0) @(negedge clk);
            chk_u0((m < 4) ? "R7 flush" : "R2 R3 stream", vec_at(m - 4));
            chk_u2((m < 6) ? "R7 flush" : "R1 R3 stream", vec_at(m - 6));
            clr = 1'b0;
            drive(vec_at(m));
            #1;
            chk_u1("R1 R8 comb", vec_at(m));
        end

        // R4: hold while enable is low, then resume without loss
        @(negedge clk);
        drive(VEC[2]);
        repeat (8) @(negedge clk);
        ce = 1'b0;
        drive(VEC[5]);
        #1;
        chk_u1("R8 enable ignored", VEC[5]);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk_u0("R4 hold", VEC[2]);
            chk_u2("R4 hold", VEC[2]);
        end
        ce = 1'b1;
        repeat (4) @(negedge clk);
        chk_u0("R4 resume", VEC[5]);
        repeat (2) @(negedge clk);
        chk_u2("R4 resume", VEC[5]);

        // R5 / R6: clear with enable low
        ce  = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        chk_u0("R5 clear wins", 64'h0);
        chk_u2("R6 clear gated", VEC[5]);
        chk_u1("R8 clear ignored", VEC[5]);
        clr = 1'b0;
        @(negedge clk);
        chk_u0("R4 hold after clear", 64'h0);
        chk_u2("R6 clear gated stays", VEC[5]);

        // R6 / R7: clear with enable high, then refill
        ce  = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        chk_u2("R6 clear with enable", 64'h0);
        clr = 1'b0;
        repeat (5) @(negedge clk);
        chk_u2("R7 zero before latency", 64'h0);
        chk_u0("R3 refill", VEC[5]);
        @(negedge clk);
        chk_u2("R7 R3 refill", VEC[5]);

        // R9: minimum operands on the narrow copy wrap only the imaginary part
        drive(64'hFF80_FF80_FE00_FE00);
        repeat (6) @(negedge clk);
        chk_u2("R9 all-min wrap", 64'hFF80_FF80_FE00_FE00);
        chk("R9 imag wraps", wrapw(longint'(o2_im), 18), -131072);
        chk_u0("R2 R9 wide", 64'hFF80_FF80_FE00_FE00);
        chk_u1("R1 R9 wide", 64'hFF80_FF80_FE00_FE00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule